// File: doc/BRIEF.md
# Serial Register Access Satellite

This block is one endpoint on a daisy-chained, bit-serial register access ring. A controller sends packets down a one-bit data line. Each packet names a satellite and a register inside it. Every satellite compares the satellite field with its own 4-bit identity, which is set by strap inputs. The satellite whose identity matches performs the read or the write on its local register file and sends a short response on the uplink data line. All other satellites stay passive and pass the uplink traffic from further down the chain on to the next hop, delayed by one clock.

A downlink packet has four parts, in this order:
- A start bit, which is always 1.
- A direction bit, where 1 means write.
- A 10-bit address, sent MSB first. The upper 4 bits are the satellite number and the lower 6 bits are the register number.
- For writes only, 64 data bits, sent MSB first.

The data line idles at 0. The response has three parts:
- A start bit of 1.
- An error bit, which is set when the register number is not implemented.
- For reads only, 64 data bits, sent MSB first.

The downlink control line resets the satellite when it is held high for two or more cycles in a row. The uplink control line is forwarded with one cycle of delay.

Top module: `ring_reg_satellite`

## Requirements
- R1: A packet starts on the first cycle in which `dl_dat_i` is 1. The fields then follow in this order: the direction bit (1 = write), 10 address bits sent MSB first (address bits [9:6] are the satellite number and bits [5:0] are the register number), and, for writes only, 64 data bits sent MSB first. After the last bit the satellite is idle again and waits for the next start bit.
- R2: A packet whose satellite number differs from `sat_id_i` changes no register and produces no response.
- R3: A matching write to an implemented register (register number below `NUM_REGS`, default 16) stores the data. The response, a 1 then an error bit of 0, appears on `ul_dat_o` starting in the cycle after the edge that samples the last data bit.
- R4: A matching read returns a 1, then an error bit, then the register's 64 bits MSB first on `ul_dat_o`. The response starts in the cycle after the edge that samples the last address bit.
- R5: A register number at or above `NUM_REGS` gives an error bit of 1. A write to such a register is dropped, and a read of it returns all zeros.
- R6: When the satellite is not sending a response, `ul_dat_o` equals `ul_dat_i` of the previous cycle. While it sends, the incoming uplink data is dropped. `ul_ctl_o` always equals `ul_ctl_i` of the previous cycle.
- R7: When `dl_ctl_i` is high in two consecutive cycles, then at the edge of the second cycle the packet state, any response in progress and all registers are cleared to zero. A high pulse of a single cycle has no effect.
- R8: A low `rst_n` at a clock edge clears all state. During reset, `ul_dat_o` and `ul_ctl_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dl_ctl_i | input | 1 | Downlink control line; a high level for two or more cycles resets the satellite |
| dl_dat_i | input | 1 | Downlink serial data (packets) |
| ul_ctl_i | input | 1 | Uplink control from the previous satellite |
| ul_dat_i | input | 1 | Uplink data from the previous satellite |
| sat_id_i | input | 4 | Strapped satellite identity |
| ul_ctl_o | output | 1 | Uplink control toward the next hop |
| ul_dat_o | output | 1 | Uplink data: own response or forwarded data |

## Verification
The embedded properties check on every cycle:
- that the uplink data follows the previous cycle's input whenever no response is due, including after a packet that did not match;
- that the uplink control is a one-cycle copy of its input;
- that a response begins with a 1;
- that at most one register is written per cycle;
- that a register with no write holds its value;
- that an unimplemented register number never writes;
- that the two-cycle control pulse leaves the parser idle and the registers at zero.

Only the bench scenarios can show the following:
- that the bit order and field positions of the packets and responses are right;
- that a read returns the value written earlier;
- that a single-cycle control pulse preserves the contents;
- that a clear in the middle of a packet lets the next packet be parsed cleanly.

The bench's reference model follows these points on every cycle.

// File: rtl/srs_pkg.sv
// Shared types for the serial register access satellite.
// Assumes: none; holds only the downlink parser state encoding.
package srs_pkg;

    // Downlink parser phases: waiting for start, direction bit, address, write data
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_DIR  = 2'd1,
        RX_ADDR = 2'd2,
        RX_DATA = 2'd3
    } rx_state_e;

endpackage

// File: rtl/srs_rx.sv
// Downlink deserializer. It frames start, direction, address and write data
// from a one-bit line. It raises req_valid_o for one cycle, combinationally,
// in the cycle whose edge samples the last bit of the packet. The address
// and data outputs include that last bit.
// Assumes: the line idles at 0, and clr_i is a synchronous clear with
// priority over everything else.
module srs_rx
    import srs_pkg::*;
#(
    parameter int SAT_W  = 4,
    parameter int REG_W  = 6,
    parameter int DATA_W = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     dl_dat_i,
    output logic                     req_valid_o,
    output logic                     req_wr_o,
    output logic [SAT_W+REG_W-1:0]   req_addr_o,
    output logic [DATA_W-1:0]        req_data_o
);
    localparam int ADDR_W = SAT_W + REG_W;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    rx_state_e           state_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                wr_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;
    logic                last_addr;
    logic                last_data;

    // Last-bit detection for both packet kinds
    always_comb begin
        last_addr = (state_q == RX_ADDR) && (cnt_q == CNT_W'(ADDR_W - 1));
        last_data = (state_q == RX_DATA) && (cnt_q == CNT_W'(DATA_W - 1));
    end

    // Packet framing state machine and field shift registers
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            case (state_q)
                RX_IDLE: begin
                    if (dl_dat_i) state_q <= RX_DIR;
                end
                RX_DIR: begin
                    wr_q    <= dl_dat_i;
                    cnt_q   <= '0;
                    state_q <= RX_ADDR;
                end
                RX_ADDR: begin
                    addr_q <= {addr_q[ADDR_W-2:0], dl_dat_i};
                    if (last_addr) begin
                        cnt_q   <= '0;
                        state_q <= wr_q ? RX_DATA : RX_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    data_q <= {data_q[DATA_W-2:0], dl_dat_i};
                    if (last_data) begin
                        cnt_q   <= '0;
                        state_q <= RX_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    // Request outputs including the bit sampled at this edge
    always_comb begin
        req_valid_o = (last_addr && !wr_q) || last_data;
        req_wr_o    = wr_q;
        req_addr_o  = (state_q == RX_ADDR) ? {addr_q[ADDR_W-2:0], dl_dat_i} : addr_q;
        req_data_o  = {data_q[DATA_W-2:0], dl_dat_i};
    end

    // R1: a direction bit is always followed by the address phase
    p_dir_then_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_DIR && !clr_i) |=> (state_q == RX_ADDR));

    // R1: once a request completes, the parser waits for the next start bit
    p_end_to_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |=> (state_q == RX_IDLE));

    // R7: a control-line clear leaves the parser idle
    p_clr_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (state_q == RX_IDLE && cnt_q == '0));

endmodule

// File: rtl/srs_regs.sv
// Local register file of the satellite. It has NUM_REGS implemented words
// out of 2**REG_W register numbers. Numbers at or above NUM_REGS raise
// err_o; writes to them are dropped and reads of them return zero.
// Assumes: at most one access per cycle; clr_i clears all words.
module srs_regs #(
    parameter int REG_W    = 6,
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               wr_en_i,
    input  logic [REG_W-1:0]   idx_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               err_o
);
    logic [DATA_W-1:0]   regs_q [NUM_REGS];
    logic [NUM_REGS-1:0] wr_vec;

    // Flag register numbers beyond the implemented range
    always_comb begin
        err_o = ({1'b0, idx_i} >= (REG_W + 1)'(NUM_REGS));
    end

    // Read mux; unimplemented numbers read as zero
    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (idx_i == REG_W'(k)) rdata_o = regs_q[k];
        end
    end

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
        // Write strobe for one word
        always_comb begin
            wr_vec[k] = wr_en_i && !err_o && (idx_i == REG_W'(k));
        end

        // Storage for one word, cleared by reset or the control-line clear
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                regs_q[k] <= '0;
            end else if (wr_vec[k]) begin
                regs_q[k] <= wdata_i;
            end
        end

        // R2: a word with no strobe keeps its value
        p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_vec[k] && !clr_i) |=> (regs_q[k] == $past(regs_q[k])));

        // R7: the clear zeroes every word
        p_clr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i |=> (regs_q[k] == '0));
    end

    // R3: at most one word is written per cycle
    p_one_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec));

    // R5: an unimplemented number never produces a write
    p_err_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && err_o) |-> (wr_vec == '0));

endmodule

// File: rtl/srs_tx.sv
// Uplink serializer and pass-through mux. A load sends a start bit at once,
// then the error bit, then, for reads, DATA_W data bits MSB first. When no
// response is pending, the output repeats the incoming uplink bit one cycle
// later.
// Assumes: the controller does not start a new matching packet while a
// response is still being sent.
module srs_tx #(
    parameter int DATA_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               load_i,
    input  logic               load_rd_i,
    input  logic               err_i,
    input  logic [DATA_W-1:0]  rdata_i,
    input  logic               ul_dat_i,
    output logic               ul_dat_o,
    output logic               busy_o
);
    localparam int SH_W  = DATA_W + 1;
    localparam int CNT_W = $clog2(SH_W + 1);

    logic [SH_W-1:0]  sh_q;
    logic [CNT_W-1:0] left_q;
    logic             out_q;

    // Response shifting, or forwarding of the downstream uplink
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            sh_q   <= '0;
            left_q <= '0;
            out_q  <= 1'b0;
        end else if (load_i) begin
            out_q  <= 1'b1;
            sh_q   <= {err_i, rdata_i};
            left_q <= load_rd_i ? CNT_W'(SH_W) : CNT_W'(1);
        end else if (left_q != '0) begin
            out_q  <= sh_q[SH_W-1];
            sh_q   <= {sh_q[SH_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end else begin
            out_q  <= ul_dat_i;
        end
    end

    // Drive the ports from the registers
    always_comb begin
        ul_dat_o = out_q;
        busy_o   = (left_q != '0);
    end

    // R3: every response starts with a 1
    p_start_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clr_i) |=> ul_dat_o);

    // R6: an idle serializer forwards the previous uplink bit
    p_forward_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !busy_o && !clr_i) |=> (ul_dat_o == $past(ul_dat_i)));

endmodule

// File: rtl/ring_reg_satellite.sv
// Top of the serial register access satellite. It joins the downlink parser,
// the register file and the uplink serializer. It matches the satellite
// field against the strapped identity and detects the two-cycle control
// clear.
// Assumes: sat_id_i is static; rst_n is a synchronous active-low reset.
module ring_reg_satellite #(
    parameter int SAT_W    = 4,
    parameter int REG_W    = 6,
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dl_ctl_i,
    input  logic              dl_dat_i,
    input  logic              ul_ctl_i,
    input  logic              ul_dat_i,
    input  logic [SAT_W-1:0]  sat_id_i,
    output logic              ul_ctl_o,
    output logic              ul_dat_o
);
    localparam int ADDR_W = SAT_W + REG_W;

    logic              ctl_d1_q;
    logic              ul_ctl_q;
    logic              clr;
    logic              req_valid;
    logic              req_wr;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_data;
    logic              hit;
    logic [DATA_W-1:0] rdata;
    logic              err;
    logic              tx_busy;

    // Control-line history and the uplink control forward register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_d1_q <= 1'b0;
            ul_ctl_q <= 1'b0;
        end else begin
            ctl_d1_q <= dl_ctl_i;
            ul_ctl_q <= ul_ctl_i;
        end
    end

    // Clear decode and identity match
    always_comb begin
        clr      = dl_ctl_i && ctl_d1_q;
        hit      = req_valid && !clr && (req_addr[ADDR_W-1 -: SAT_W] == sat_id_i);
        ul_ctl_o = ul_ctl_q;
    end

    srs_rx #(
        .SAT_W  (SAT_W),
        .REG_W  (REG_W),
        .DATA_W (DATA_W)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr),
        .dl_dat_i    (dl_dat_i),
        .req_valid_o (req_valid),
        .req_wr_o    (req_wr),
        .req_addr_o  (req_addr),
        .req_data_o  (req_data)
    );

    srs_regs #(
        .REG_W    (REG_W),
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .wr_en_i (hit && req_wr),
        .idx_i   (req_addr[REG_W-1:0]),
        .wdata_i (req_data),
        .rdata_o (rdata),
        .err_o   (err)
    );

    srs_tx #(
        .DATA_W (DATA_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .load_i    (hit),
        .load_rd_i (!req_wr),
        .err_i     (err),
        .rdata_i   (rdata),
        .ul_dat_i  (ul_dat_i),
        .ul_dat_o  (ul_dat_o),
        .busy_o    (tx_busy)
    );

    // R6: uplink control is a one-cycle copy of its input
    p_ctl_forward_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ul_ctl_o == $past(ul_ctl_i)));

    // R2: a packet for another satellite leaves the uplink forwarding
    p_miss_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !clr && !tx_busy && (req_addr[ADDR_W-1 -: SAT_W] != sat_id_i))
        |=> (ul_dat_o == $past(ul_dat_i)));

endmodule

// File: tb/ring_reg_satellite_tb.sv
`timescale 1ns/1ps
module ring_reg_satellite_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dl_ctl = 1'b0;
    logic       dl_dat = 1'b0;
    logic       ul_ctl_in = 1'b0;
    logic       ul_dat_in = 1'b0;
    logic [3:0] sat_id = 4'hA;
    logic       ul_ctl_out;
    logic       ul_dat_out;

    int    total = 0;
    int    bad = 0;
    string cur_tag = "R8";
    bit    started = 1'b0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    ring_reg_satellite u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .dl_ctl_i (dl_ctl),
        .dl_dat_i (dl_dat),
        .ul_ctl_i (ul_ctl_in),
        .ul_dat_i (ul_dat_in),
        .sat_id_i (sat_id),
        .ul_ctl_o (ul_ctl_out),
        .ul_dat_o (ul_dat_out)
    );

    // ---------------- behavioural reference model ----------------
    int          m_phase = 0;
    int          m_cnt = 0;
    bit          m_wr = 0;
    int          m_addr = 0;
    logic [63:0] m_data = '0;
    logic [63:0] m_regs [64];
    bit          m_q [$];
    bit          m_ctl_prev = 0;
    bit          exp_ul = 0;
    bit          exp_ctl = 0;

    task automatic model_clear();
        m_phase = 0; m_cnt = 0; m_wr = 0; m_addr = 0; m_data = '0;
        for (int i = 0; i < 64; i++) m_regs[i] = '0;
        m_q.delete();
        exp_ul = 0;
    endtask

    always @(posedge clk) begin
        bit acc;
        int r;
        bit e;
        started = 1'b1;
        if (!rst_n) begin
            model_clear();
            m_ctl_prev = 0;
            exp_ctl = 0;
        end else begin
            bit clr;
            clr = dl_ctl && m_ctl_prev;
            exp_ctl = ul_ctl_in;
            m_ctl_prev = dl_ctl;
            if (clr) begin
                model_clear();
            end else begin
                acc = 0;
                case (m_phase)
                    0: if (dl_dat) m_phase = 1;
                    1: begin m_wr = dl_dat; m_cnt = 0; m_addr = 0; m_phase = 2; end
                    2: begin
                        m_addr = (m_addr << 1) | int'(dl_dat);
                        m_cnt++;
                        if (m_cnt == 10) begin
                            m_cnt = 0;
                            if (m_wr) m_phase = 3;
                            else begin m_phase = 0; acc = 1; end
                        end
                    end
                    default: begin
                        m_data = {m_data[62:0], dl_dat};
                        m_cnt++;
                        if (m_cnt == 64) begin m_phase = 0; acc = 1; end
                    end
                endcase
                if (acc && ((m_addr >> 6) & 15) == int'(sat_id)) begin
                    r = m_addr & 63;
                    e = (r >= 16);
                    if (m_wr && !e) m_regs[r] = m_data;
                    exp_ul = 1;
                    m_q.delete();
                    m_q.push_back(e);
                    if (!m_wr) for (int i = 63; i >= 0; i--) m_q.push_back(e ? 1'b0 : m_regs[r][i]);
                end else if (m_q.size() > 0) begin
                    exp_ul = m_q.pop_front();
                end else begin
                    exp_ul = ul_dat_in;
                end
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            total++;
            if (ul_dat_out !== exp_ul) begin
                bad++;
                $display("FAIL %s: ul_dat_o=%0b expected %0b at %0t", cur_tag, ul_dat_out, exp_ul, $time);
            end
            total++;
            if (ul_ctl_out !== exp_ctl) begin
                bad++;
                $display("FAIL R6: ul_ctl_o=%0b expected %0b at %0t", ul_ctl_out, exp_ctl, $time);
            end
        end
    end

    // Downstream uplink traffic from a small LFSR
    initial begin
        logic [7:0] lf;
        lf = 8'hB5;
        forever begin
            @(negedge clk);
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            ul_dat_in = lf[0];
            ul_ctl_in = lf[3];
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_pkt(input bit wr, input logic [3:0] sat, input logic [5:0] rn, input logic [63:0] d);
        dl_dat = 1'b1; @(negedge clk);
        dl_dat = wr;   @(negedge clk);
        for (int i = 3; i >= 0; i--) begin dl_dat = sat[i]; @(negedge clk); end
        for (int i = 5; i >= 0; i--) begin dl_dat = rn[i]; @(negedge clk); end
        if (wr) for (int i = 63; i >= 0; i--) begin dl_dat = d[i]; @(negedge clk); end
        dl_dat = 1'b0;
    endtask

    task automatic write_check(input logic [5:0] rn, input logic [63:0] d, input bit exp_err, input string tag);
        send_pkt(1'b1, sat_id, rn, d);
        check({tag, " start"}, 64'(ul_dat_out), 64'd1);
        @(negedge clk);
        check({tag, " err"}, 64'(ul_dat_out), 64'(exp_err));
        repeat (2) @(negedge clk);
    endtask

    task automatic read_check(input logic [5:0] rn, input logic [63:0] exp_d, input bit exp_err, input string tag);
        logic [63:0] got;
        send_pkt(1'b0, sat_id, rn, '0);
        check({tag, " start"}, 64'(ul_dat_out), 64'd1);
        @(negedge clk);
        check({tag, " err"}, 64'(ul_dat_out), 64'(exp_err));
        for (int i = 63; i >= 0; i--) begin @(negedge clk); got[i] = ul_dat_out; end
        check({tag, " data"}, got, exp_d);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_ctl(input int n);
        dl_ctl = 1'b1;
        repeat (n) @(negedge clk);
        dl_ctl = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        cur_tag = "R8";
        repeat (3) @(negedge clk);
        check("R8 reset ul_dat_o", 64'(ul_dat_out), 64'd0);
        check("R8 reset ul_ctl_o", 64'(ul_ctl_out), 64'd0);
        rst_n = 1'b1;
        cur_tag = "R6";
        repeat (6) @(negedge clk);

        cur_tag = "R3";
        write_check(6'd3, 64'hDEAD_BEEF_0123_4567, 1'b0, "R3 write reg3");
        cur_tag = "R4";
        read_check(6'd3, 64'hDEAD_BEEF_0123_4567, 1'b0, "R4 read reg3");
        cur_tag = "R1";
        write_check(6'd0, 64'h8000_0000_0000_0001, 1'b0, "R1 edge bits reg0");
        read_check(6'd0, 64'h8000_0000_0000_0001, 1'b0, "R1 read reg0");
        write_check(6'd15, 64'h5555_AAAA_0F0F_F0F0, 1'b0, "R3 top reg15");
        read_check(6'd15, 64'h5555_AAAA_0F0F_F0F0, 1'b0, "R4 read reg15");

        cur_tag = "R2";
        send_pkt(1'b1, 4'h5, 6'd3, 64'h1111_2222_3333_4444);
        repeat (4) @(negedge clk);
        send_pkt(1'b0, 4'hB, 6'd3, '0);
        repeat (70) @(negedge clk);
        read_check(6'd3, 64'hDEAD_BEEF_0123_4567, 1'b0, "R2 other id no write");

        cur_tag = "R5";
        write_check(6'd16, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R5 write reg16");
        read_check(6'd16, 64'h0, 1'b1, "R5 read reg16");
        read_check(6'd63, 64'h0, 1'b1, "R5 read reg63");

        cur_tag = "R7";
        pulse_ctl(1);
        read_check(6'd3, 64'hDEAD_BEEF_0123_4567, 1'b0, "R7 single pulse keeps");
        dl_dat = 1'b1; @(negedge clk);
        dl_dat = 1'b0; @(negedge clk);
        dl_dat = 1'b1; repeat (3) @(negedge clk);
        dl_dat = 1'b0;
        pulse_ctl(2);
        read_check(6'd3, 64'h0, 1'b0, "R7 double pulse clears");
        read_check(6'd15, 64'h0, 1'b0, "R7 double pulse clears reg15");

        cur_tag = "R8";
        write_check(6'd5, 64'h0123_4567_89AB_CDEF, 1'b0, "R8 pre-reset write");
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 mid reset ul_dat_o", 64'(ul_dat_out), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        read_check(6'd5, 64'h0, 1'b0, "R8 reset clears reg5");

        cur_tag = "R6";
        repeat (20) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule